// File: doc/BRIEF.md
# Ping-Pong Frame Descriptor Sequencer

This block sequences a video frame reader one frame at a time. Software uses a 32-bit register port to program two frame descriptors. It picks which descriptor the next frame uses through a select register, and turns the engine on with a run bit. Each descriptor holds a memory start address, a word count, a count of single-cycle colour patterns, a picture width, a picture height and an interlace nibble.

When the engine is enabled and idle, the block copies the selected descriptor into a private shadow. It then offers a read command (address, word count, pattern count) on a valid/ready handshake. For the whole frame it holds the width, height and interlace values on dedicated packet-field outputs, and a strobe marks the start of the frame. It then waits for a frame-done pulse from the datapath, sets a sticky end-of-frame flag and raises the interrupt when that is enabled. Because the descriptor is copied only at frame start, software can rewrite any register mid-frame and prepare the following frame.

Top module: `frame_reader_ctrl`

## Requirements
- R1: After reset every readable register reads 0, `cmd_valid`, `pkt_strobe` and `irq` are 0, and the packet-field outputs are 0.
- R2: Register word addresses are 0 control (bit 0 run, bit 1 interrupt enable), 1 status, 2 interrupt flag, 3 select (bit 0). Slot 0 occupies 4..10 and slot 1 occupies 11..17. Within a slot the offsets are 0 start address, 1 word count, 2 pattern count, 3 unused, 4 width, 5 height, 6 interlace. Width and height keep the low 16 bits, interlace keeps the low 4 bits, and every stored field reads back zero-extended.
- R3: The unused slot words (addresses 7 and 14) and every address above 17 read 0, and writes to them change nothing.
- R4: While the run bit is 1 and the block is idle, a frame starts. The slot chosen by select bit 0 is captured, and `cmd_valid` rises with its start address, word count and pattern count. While the run bit is 0 no frame starts.
- R5: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid` and all three command fields hold their values.
- R6: The width, height and interlace outputs show the captured slot for the whole frame. Writes to the select or slot registers during a frame change neither the command nor the packet fields of that frame, and they take effect at the next frame start.
- R7: `pkt_strobe` is a one-cycle pulse in the first cycle that `cmd_valid` is high for each frame.
- R8: Status bit 0 is 1 from frame start until the frame-done pulse is accepted. A `frame_done` pulse that arrives before the command handshake is ignored.
- R9: If the run bit is cleared during a frame, that frame still completes and sets the end-of-frame flag. Status falls only after `frame_done`, and no new frame starts.
- R10: Bit 1 of the interrupt register becomes 1 when a frame completes. Writing 1 to bit 1 clears it and writing 0 leaves it unchanged. A completion in the same cycle as a clearing write leaves it set.
- R11: `irq` equals the end-of-frame flag ANDed with control bit 1. With the enable at 0, `irq` stays 0 while the flag still reads back.
- R12: With the run bit held at 1, the next frame starts exactly one idle cycle after the frame-done pulse, using the select value current at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 5 | Register word address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr`, combinational |
| cmd_valid | output | 1 | Read command offered |
| cmd_ready | input | 1 | Read command accepted |
| cmd_addr | output | 32 | Frame start address in memory |
| cmd_words | output | 32 | Number of memory words to read |
| cmd_patterns | output | 32 | Number of single-cycle colour patterns |
| frame_done | input | 1 | Datapath finished the current frame |
| pkt_width | output | 16 | Captured picture width |
| pkt_height | output | 16 | Captured picture height |
| pkt_interlace | output | 4 | Captured interlace nibble |
| pkt_strobe | output | 1 | One-cycle frame-start marker |
| irq | output | 1 | End-of-frame interrupt |

## Verification
Directed frames alternate between the two slots. Some slots are rewritten while a command is still pending, and the tests show whether the outputs come from the frame-start shadow or from the live registers. Other directed cases cover the pulses that separate the handshake order and the flag priority: a frame-done pulse before the handshake, a clearing write of 0 versus 1, and a clear in the same cycle as a completion. A random phase then runs back-to-back frames with random slot contents, select changes and handshake stalls. Each frame is compared with the expectation recorded at the previous frame's end, which confirms the one-frame lag of every register write.

// File: rtl/frc_pkg.sv
package frc_pkg;

    localparam int WORD_W     = 32;
    localparam int DIM_W      = 16;
    localparam int ILACE_W    = 4;
    localparam int NUM_SLOTS  = 2;
    localparam int SLOT_WORDS = 7;
    localparam int SLOT_BASE  = 4;
    localparam int SEL_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int LAST_ADDR  = SLOT_BASE + NUM_SLOTS * SLOT_WORDS - 1;
    localparam int ADDR_W     = $clog2(LAST_ADDR + 1);

    localparam int REG_CTRL = 0;
    localparam int REG_STAT = 1;
    localparam int REG_IRQ  = 2;
    localparam int REG_SEL  = 3;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_IE_BIT  = 1;
    localparam int IRQ_EOF_BIT  = 1;

    localparam int FLD_BASE   = 0;
    localparam int FLD_WORDS  = 1;
    localparam int FLD_PATS   = 2;
    localparam int FLD_WIDTH  = 4;
    localparam int FLD_HEIGHT = 5;
    localparam int FLD_ILACE  = 6;

    typedef struct packed {
        logic [WORD_W-1:0]  base;
        logic [WORD_W-1:0]  words;
        logic [WORD_W-1:0]  pats;
        logic [DIM_W-1:0]   width;
        logic [DIM_W-1:0]   height;
        logic [ILACE_W-1:0] ilace;
    } slot_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CMD  = 2'd1,
        SQ_WAIT = 2'd2
    } seq_state_e;

    function automatic logic [WORD_W-1:0] slot_read(slot_t s, int fld);
        logic [WORD_W-1:0] v;
        v = '0;
        case (fld)
            FLD_BASE:   v = s.base;
            FLD_WORDS:  v = s.words;
            FLD_PATS:   v = s.pats;
            FLD_WIDTH:  v[DIM_W-1:0] = s.width;
            FLD_HEIGHT: v[DIM_W-1:0] = s.height;
            FLD_ILACE:  v[ILACE_W-1:0] = s.ilace;
            default:    v = '0;
        endcase
        return v;
    endfunction

    function automatic slot_t slot_write(slot_t s, int fld, logic [WORD_W-1:0] v);
        slot_t r;
        r = s;
        case (fld)
            FLD_BASE:   r.base = v;
            FLD_WORDS:  r.words = v;
            FLD_PATS:   r.pats = v;
            FLD_WIDTH:  r.width = v[DIM_W-1:0];
            FLD_HEIGHT: r.height = v[DIM_W-1:0];
            FLD_ILACE:  r.ilace = v[ILACE_W-1:0];
            default:    r = s;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/frc_csr.sv
module frc_csr
    import frc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              running,
    input  logic              eof_flag,
    output logic              run_en,
    output logic              irq_en,
    output logic [SEL_W-1:0]  sel,
    output slot_t             slots [NUM_SLOTS],
    output logic              eof_clr
);

    int addr_i;
    assign addr_i = int'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_en <= 1'b0;
            irq_en <= 1'b0;
            sel    <= '0;
        end else if (wr_en) begin
            if (addr_i == REG_CTRL) begin
                run_en <= wdata[CTRL_RUN_BIT];
                irq_en <= wdata[CTRL_IE_BIT];
            end
            if (addr_i == REG_SEL) begin
                sel <= wdata[SEL_W-1:0];
            end
        end
    end

    assign eof_clr = wr_en && (addr_i == REG_IRQ) && wdata[IRQ_EOF_BIT];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam int LO = SLOT_BASE + g * SLOT_WORDS;
        logic hit;
        assign hit = (addr_i >= LO) && (addr_i < LO + SLOT_WORDS);

        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '0;
            end else if (wr_en && hit) begin
                slots[g] <= slot_write(slots[g], addr_i - LO, wdata);
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr_i)
            REG_CTRL: begin
                rdata[CTRL_RUN_BIT] = run_en;
                rdata[CTRL_IE_BIT]  = irq_en;
            end
            REG_STAT: rdata[0] = running;
            REG_IRQ:  rdata[IRQ_EOF_BIT] = eof_flag;
            REG_SEL:  rdata[SEL_W-1:0] = sel;
            default: begin
                for (int s = 0; s < NUM_SLOTS; s++) begin
                    if (addr_i >= SLOT_BASE + s * SLOT_WORDS &&
                        addr_i <  SLOT_BASE + (s + 1) * SLOT_WORDS) begin
                        rdata = slot_read(slots[s], addr_i - SLOT_BASE - s * SLOT_WORDS);
                    end
                end
            end
        endcase
    end

    // R2
    sel_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr_i == REG_SEL) |=> (sel == $past(wdata[SEL_W-1:0])));

endmodule

// File: rtl/frc_sequencer.sv
module frc_sequencer
    import frc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run_en,
    input  logic [SEL_W-1:0]   sel,
    input  slot_t              slots [NUM_SLOTS],
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [WORD_W-1:0]  cmd_addr,
    output logic [WORD_W-1:0]  cmd_words,
    output logic [WORD_W-1:0]  cmd_pats,
    input  logic               frame_done,
    output logic [DIM_W-1:0]   pkt_width,
    output logic [DIM_W-1:0]   pkt_height,
    output logic [ILACE_W-1:0] pkt_ilace,
    output logic               pkt_strobe,
    output logic               running,
    output logic               eof_pulse
);

    seq_state_e state;
    slot_t      shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_IDLE;
            shadow     <= '0;
            pkt_strobe <= 1'b0;
        end else begin
            pkt_strobe <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (run_en) begin
                        shadow     <= slots[sel];
                        state      <= SQ_CMD;
                        pkt_strobe <= 1'b1;
                    end
                end
                SQ_CMD: begin
                    if (cmd_ready) state <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (frame_done) state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign cmd_valid  = (state == SQ_CMD);
    assign running    = (state != SQ_IDLE);
    assign eof_pulse  = (state == SQ_WAIT) && frame_done;
    assign cmd_addr   = shadow.base;
    assign cmd_words  = shadow.words;
    assign cmd_pats   = shadow.pats;
    assign pkt_width  = shadow.width;
    assign pkt_height = shadow.height;
    assign pkt_ilace  = shadow.ilace;

    // R5
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
                                       $stable(cmd_words) && $stable(cmd_pats)));

    // R6
    pkt_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (running && !pkt_strobe) |-> ($stable(pkt_width) && $stable(pkt_height) &&
                                      $stable(pkt_ilace)));

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_strobe |-> (cmd_valid && $rose(running)));

    // R8
    run_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> $past(frame_done));

endmodule

// File: rtl/frc_irq.sv
module frc_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic enable,
    output logic flag,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr_evt) begin
            flag <= 1'b0;
        end
    end

    assign irq = flag && enable;

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> ($past(clr_evt) && !$past(set_evt)));

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(set_evt));

endmodule

// File: rtl/frame_reader_ctrl.sv
module frame_reader_ctrl
    import frc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               csr_wr,
    input  logic [ADDR_W-1:0]  csr_addr,
    input  logic [WORD_W-1:0]  csr_wdata,
    output logic [WORD_W-1:0]  csr_rdata,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [WORD_W-1:0]  cmd_addr,
    output logic [WORD_W-1:0]  cmd_words,
    output logic [WORD_W-1:0]  cmd_patterns,
    input  logic               frame_done,
    output logic [DIM_W-1:0]   pkt_width,
    output logic [DIM_W-1:0]   pkt_height,
    output logic [ILACE_W-1:0] pkt_interlace,
    output logic               pkt_strobe,
    output logic               irq
);

    logic             run_en;
    logic             irq_en;
    logic [SEL_W-1:0] sel;
    slot_t            slots [NUM_SLOTS];
    logic             eof_clr;
    logic             eof_pulse;
    logic             eof_flag;
    logic             running;

    frc_csr u_csr (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (csr_wr),
        .addr     (csr_addr),
        .wdata    (csr_wdata),
        .rdata    (csr_rdata),
        .running  (running),
        .eof_flag (eof_flag),
        .run_en   (run_en),
        .irq_en   (irq_en),
        .sel      (sel),
        .slots    (slots),
        .eof_clr  (eof_clr)
    );

    frc_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .sel        (sel),
        .slots      (slots),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_addr   (cmd_addr),
        .cmd_words  (cmd_words),
        .cmd_pats   (cmd_patterns),
        .frame_done (frame_done),
        .pkt_width  (pkt_width),
        .pkt_height (pkt_height),
        .pkt_ilace  (pkt_interlace),
        .pkt_strobe (pkt_strobe),
        .running    (running),
        .eof_pulse  (eof_pulse)
    );

    frc_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_evt (eof_pulse),
        .clr_evt (eof_clr),
        .enable  (irq_en),
        .flag    (eof_flag),
        .irq     (irq)
    );

    // R9
    no_start_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (!running && !run_en) |=> !cmd_valid);

endmodule

// File: tb/frame_reader_ctrl_tb.sv
module frame_reader_ctrl_tb;
    import frc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int SEED       = 1234;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               csr_wr = 1'b0;
    logic [ADDR_W-1:0]  csr_addr = '0;
    logic [WORD_W-1:0]  csr_wdata = '0;
    logic [WORD_W-1:0]  csr_rdata;
    logic               cmd_valid;
    logic               cmd_ready = 1'b0;
    logic [WORD_W-1:0]  cmd_addr;
    logic [WORD_W-1:0]  cmd_words;
    logic [WORD_W-1:0]  cmd_patterns;
    logic               frame_done = 1'b0;
    logic [DIM_W-1:0]   pkt_width;
    logic [DIM_W-1:0]   pkt_height;
    logic [ILACE_W-1:0] pkt_interlace;
    logic               pkt_strobe;
    logic               irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_base [2];
    logic [31:0] m_words[2];
    logic [31:0] m_pats [2];
    logic [31:0] m_w    [2];
    logic [31:0] m_h    [2];
    logic [31:0] m_il   [2];
    int          m_sel = 0;

    logic [31:0] e_base, e_words, e_pats, e_w, e_h, e_il;
    logic [31:0] c_base, c_words, c_pats, c_w, c_h, c_il;

    always #(CLK_PERIOD / 2) clk = ~clk;

    frame_reader_ctrl u_dut (
        .clk           (clk),
        .rst           (rst),
        .csr_wr        (csr_wr),
        .csr_addr      (csr_addr),
        .csr_wdata     (csr_wdata),
        .csr_rdata     (csr_rdata),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_addr      (cmd_addr),
        .cmd_words     (cmd_words),
        .cmd_patterns  (cmd_patterns),
        .frame_done    (frame_done),
        .pkt_width     (pkt_width),
        .pkt_height    (pkt_height),
        .pkt_interlace (pkt_interlace),
        .pkt_strobe    (pkt_strobe),
        .irq           (irq)
    );

    function automatic int slot_addr(int s, int f);
        return 4 + 7 * s + f;
    endfunction

    function automatic logic [31:0] exp_field(int s, int f);
        case (f)
            0: return m_base[s];
            1: return m_words[s];
            2: return m_pats[s];
            4: return m_w[s];
            5: return m_h[s];
            6: return m_il[s];
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        csr_addr  = ADDR_W'(a);
        csr_wdata = d;
        csr_wr    = 1'b1;
        tick();
        csr_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        csr_addr = ADDR_W'(a);
        #1;
        v = csr_rdata;
    endtask

    task automatic chk_rd(input string tag, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic write_field(input int s, input int f, input logic [31:0] d);
        wr(slot_addr(s, f), d);
        case (f)
            0: m_base[s]  = d;
            1: m_words[s] = d;
            2: m_pats[s]  = d;
            4: m_w[s]     = {16'd0, d[15:0]};
            5: m_h[s]     = {16'd0, d[15:0]};
            6: m_il[s]    = {28'd0, d[3:0]};
            default: ;
        endcase
    endtask

    task automatic rand_slot(input int s);
        for (int f = 0; f < 7; f++) begin
            if (f != 3) write_field(s, f, $urandom);
        end
    endtask

    task automatic snap();
        e_base  = m_base[m_sel];
        e_words = m_words[m_sel];
        e_pats  = m_pats[m_sel];
        e_w     = m_w[m_sel];
        e_h     = m_h[m_sel];
        e_il    = m_il[m_sel];
    endtask

    task automatic set_sel(input int s);
        wr(3, s);
        m_sel = s;
    endtask

    task automatic chk_cur(input string tag);
        chk({tag, " cmd_valid"}, {31'd0, cmd_valid}, 32'd1);
        chk({tag, " cmd_addr"}, cmd_addr, c_base);
        chk({tag, " cmd_words"}, cmd_words, c_words);
        chk({tag, " cmd_patterns"}, cmd_patterns, c_pats);
        chk({tag, " pkt_width"}, {16'd0, pkt_width}, c_w);
        chk({tag, " pkt_height"}, {16'd0, pkt_height}, c_h);
        chk({tag, " pkt_interlace"}, {28'd0, pkt_interlace}, c_il);
    endtask

    // Waits for a frame start, checks it against the expected snapshot (R4 R6 R7)
    task automatic start_frame(input string tag);
        int n = 0;
        while (!cmd_valid && n < 16) begin
            tick();
            n++;
        end
        c_base = e_base; c_words = e_words; c_pats = e_pats;
        c_w = e_w; c_h = e_h; c_il = e_il;
        chk({tag, " R4 frame start"}, {31'd0, cmd_valid}, 32'd1);
        chk_cur({tag, " R4 R6 captured"});
        chk({tag, " R7 strobe at start"}, {31'd0, pkt_strobe}, 32'd1);
    endtask

    task automatic handshake(input string tag, input int delay);
        for (int i = 0; i < delay; i++) begin
            tick();
            chk_cur({tag, " R5 held"});
            chk({tag, " R7 strobe low"}, {31'd0, pkt_strobe}, 32'd0);
        end
        cmd_ready = 1'b1;
        tick();
        cmd_ready = 1'b0;
        chk({tag, " R5 accepted"}, {31'd0, cmd_valid}, 32'd0);
    endtask

    task automatic end_frame();
        frame_done = 1'b1;
        tick();
        frame_done = 1'b0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(SEED));
        for (int s = 0; s < 2; s++) begin
            m_base[s] = 0; m_words[s] = 0; m_pats[s] = 0;
            m_w[s] = 0; m_h[s] = 0; m_il[s] = 0;
        end
        repeat (3) tick();
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 32; a++) chk_rd("R1 reset read", a, 32'd0);
        chk("R1 cmd_valid", {31'd0, cmd_valid}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 pkt_strobe", {31'd0, pkt_strobe}, 32'd0);
        chk("R1 pkt_width", {16'd0, pkt_width}, 32'd0);

        // R2 map and readback
        rand_slot(0);
        rand_slot(1);
        for (int s = 0; s < 2; s++)
            for (int f = 0; f < 7; f++)
                chk_rd("R2 slot readback", slot_addr(s, f), exp_field(s, f));
        wr(0, 32'hFFFF_FFFE);
        chk_rd("R2 control readback", 0, 32'd2);
        chk_rd("R2 status idle", 1, 32'd0);

        // R3 unused words and out-of-range addresses
        wr(7, $urandom);
        wr(14, 32'hFFFF_FFFF);
        wr(20, 32'hFFFF_FFFF);
        chk_rd("R3 unused word 7", 7, 32'd0);
        chk_rd("R3 unused word 14", 14, 32'd0);
        for (int a = 18; a < 32; a++) chk_rd("R3 above map", a, 32'd0);
        for (int s = 0; s < 2; s++)
            for (int f = 0; f < 7; f++)
                chk_rd("R3 write to unused ignored", slot_addr(s, f), exp_field(s, f));
        chk_rd("R3 control untouched", 0, 32'd2);

        // R4 no start while run bit is 0
        repeat (4) tick();
        chk("R4 idle without run", {31'd0, cmd_valid}, 32'd0);

        // Frame A: slot 1, rewrite during frame
        set_sel(1);
        snap();
        wr(0, 32'd3);
        start_frame("frameA");
        chk_rd("R8 status running", 1, 32'd1);
        rand_slot(1);
        set_sel(0);
        snap();
        chk_cur("frameA R6 after rewrite");
        chk("R7 strobe one cycle", {31'd0, pkt_strobe}, 32'd0);
        end_frame();
        chk("R8 early done ignored", {31'd0, cmd_valid}, 32'd1);
        chk_rd("R8 early done status", 1, 32'd1);
        chk_rd("R8 early done no flag", 2, 32'd0);
        handshake("frameA", 2);
        chk_rd("R8 status in wait", 1, 32'd1);
        chk("R6 pkt_width in wait", {16'd0, pkt_width}, c_w);
        end_frame();
        chk("R10 irq after done", {31'd0, irq}, 32'd1);
        chk_rd("R10 flag after done", 2, 32'd2);
        chk_rd("R12 idle gap status", 1, 32'd0);
        chk("R12 idle gap", {31'd0, cmd_valid}, 32'd0);
        tick();
        chk("R12 restart after one cycle", {31'd0, cmd_valid}, 32'd1);
        start_frame("frameB R6 next select");

        // R10 clear semantics
        wr(2, 32'hFFFF_FFFD);
        chk("R10 write 0 keeps flag", {31'd0, irq}, 32'd1);
        wr(2, 32'd2);
        chk("R10 write 1 clears", {31'd0, irq}, 32'd0);
        chk_rd("R10 flag cleared", 2, 32'd0);

        // R9 stop during frame
        wr(0, 32'd2);
        chk_rd("R9 still running", 1, 32'd1);
        handshake("frameB", 1);
        repeat (3) tick();
        chk_rd("R9 running until done", 1, 32'd1);
        end_frame();
        chk_rd("R9 status falls after done", 1, 32'd0);
        chk("R9 frame raised irq", {31'd0, irq}, 32'd1);
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R9 no new frame", {31'd0, cmd_valid}, 32'd0);
        end

        // R11 enable off
        wr(2, 32'd2);
        snap();
        wr(0, 32'd1);
        start_frame("frameC");
        handshake("frameC", 0);
        end_frame();
        chk("R11 irq masked", {31'd0, irq}, 32'd0);
        chk_rd("R11 flag visible", 2, 32'd2);
        snap();
        wr(0, 32'd3);
        chk("R11 irq after enable", {31'd0, irq}, 32'd1);

        // R10 set wins over clear in same cycle
        start_frame("frameD");
        wr(2, 32'd2);
        chk("R10 cleared before race", {31'd0, irq}, 32'd0);
        handshake("frameD", 0);
        frame_done = 1'b1;
        csr_addr   = ADDR_W'(2);
        csr_wdata  = 32'd2;
        csr_wr     = 1'b1;
        tick();
        frame_done = 1'b0;
        csr_wr     = 1'b0;
        chk_rd("R10 set wins", 2, 32'd2);
        chk("R10 set wins irq", {31'd0, irq}, 32'd1);

        // Random back-to-back frames
        for (int it = 0; it < 40; it++) begin
            start_frame("rand");
            if ($urandom % 2 == 1) rand_slot($urandom % 2);
            if ($urandom % 2 == 1) set_sel($urandom % 2);
            snap();
            handshake("rand", $urandom % 4);
            for (int k = 0; k < int'($urandom % 3); k++) begin
                tick();
                chk_rd("R8 rand running", 1, 32'd1);
            end
            end_frame();
            chk("R10 rand irq", {31'd0, irq}, 32'd1);
            wr(2, 32'd2);
        end

        summary();
        $finish;
    end

endmodule